// File: doc/BRIEF.md
# Arithmetic Unit with Next-PC Selection

This block is the arithmetic stage of a small multicycle processor whose datapath is eight bits wide. It takes two operands that the surrounding datapath has already chosen. A two-bit operation mode and the instruction's six-bit function field together select one of five operations: add, subtract, bitwise AND, bitwise OR and signed set-less-than. The block drives the live result and a flag that is high when that result is zero.

The block keeps a copy of the result in a register on every clock edge. A two-bit source select then forms the next program-counter value from one of three sources: the live result, that held copy, or the instruction's jump field shifted left by two places. The control sequencer uses this to step the PC, to commit a branch target computed in an earlier cycle, or to take a jump, all without a separate adder.

Top module: `alu_pc_unit`

## Requirements
- R1: With mode 00, result is (A + B) mod 256 whatever the function field holds.
- R2: With mode 01, result is (A - B) mod 256 whatever the function field holds.
- R3: With mode 10 or 11, the function field selects the operation: 100000 add, 100010 subtract, 100100 bitwise AND, 100101 bitwise OR, 101010 set-less-than.
- R4: With mode 10 or 11 and any function value not listed in R3, the block adds.
- R5: Set-less-than gives 00000001 when A is smaller than B as two's complement numbers, and 00000000 otherwise.
- R6: The zero flag is high exactly when the live result is 00000000.
- R7: The held result takes the live result at every rising clock edge and is cleared by a synchronous active-high reset. It is observable on next_pc with source select 01.
- R8: next_pc equals the live result for source select 00 and 11, and equals the jump field shifted left by two with its top two bits dropped and zeros filled in for source select 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the held result |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| alu_mode | input | 2 | Operation mode from the sequencer |
| funct | input | 6 | Instruction function field |
| jump_field | input | 8 | Jump target field of the instruction |
| pc_src | input | 2 | Next-PC source select |
| result | output | 8 | Live arithmetic result |
| zero | output | 1 | High when result is all zeros |
| next_pc | output | 8 | Selected next program-counter value |

## Verification
On every cycle the assertions check several properties. The fixed modes must force add or subtract in the decoder. Set-less-than must never set any bit above bit zero. The held register must always carry the previous cycle's result. The jump path must always give a word-aligned value. The arithmetic itself can only be shown by the bench's sweeps, computed independently: wrap-around, signed comparison across the sign boundary, the fallback for unknown function codes, the zero flag, and each of the four source selections, including a reset that clears the held result mid-run.

// File: rtl/alu_pc_pkg.sv
package alu_pc_pkg;

    localparam int DATA_W  = 8;
    localparam int FUNCT_W = 6;
    localparam int MODE_W  = 2;
    localparam int SEL_W   = 2;
    localparam int CTL_W   = 3;

    typedef enum logic [CTL_W-1:0] {
        CTL_AND = 3'b000,
        CTL_OR  = 3'b001,
        CTL_ADD = 3'b010,
        CTL_SUB = 3'b110,
        CTL_SLT = 3'b111
    } alu_ctl_e;

    typedef enum logic [SEL_W-1:0] {
        PCS_LIVE     = 2'b00,
        PCS_HELD     = 2'b01,
        PCS_JUMP     = 2'b10,
        PCS_LIVE_ALT = 2'b11
    } pc_src_e;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

    // Map a function field to an operation; unknown codes fall back to add.
    function automatic alu_ctl_e funct_to_ctl(input logic [FUNCT_W-1:0] fn);
        alu_ctl_e c;
        case (fn)
            FN_SUB:  c = CTL_SUB;
            FN_AND:  c = CTL_AND;
            FN_OR:   c = CTL_OR;
            FN_SLT:  c = CTL_SLT;
            default: c = CTL_ADD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
    import alu_pc_pkg::*;
#(
    parameter int FW = FUNCT_W
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [FW-1:0]     fn,
    output alu_ctl_e          ctl
);

    always_comb begin
        if (mode[1]) begin
            ctl = funct_to_ctl(fn[FUNCT_W-1:0]);
        end else if (mode[0]) begin
            ctl = CTL_SUB;
        end else begin
            ctl = CTL_ADD;
        end
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_ctl_e     ctl,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);

    logic         sub_en;
    logic [W-1:0] b_eff;
    logic [W:0]   sum;
    logic         ovf;
    logic         less;

    // One shared adder: subtraction inverts B and injects a carry.
    assign sub_en = (ctl == CTL_SUB) || (ctl == CTL_SLT);
    assign b_eff  = b ^ {W{sub_en}};
    assign sum    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub_en};

    // Signed less-than from the difference sign, corrected for overflow.
    assign ovf  = (a[W-1] != b[W-1]) && (sum[W-1] != a[W-1]);
    assign less = sum[W-1] ^ ovf;

    always_comb begin
        case (ctl)
            CTL_AND: y = a & b;
            CTL_OR:  y = a | b;
            CTL_SLT: y = {{(W-1){1'b0}}, less};
            default: y = sum[W-1:0];
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
    import alu_pc_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int SHIFT = 2
) (
    input  pc_src_e      sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] held,
    input  logic [W-1:0] jump,
    output logic [W-1:0] pc
);

    logic [W-1:0] jump_shifted;

    assign jump_shifted = {jump[W-SHIFT-1:0], {SHIFT{1'b0}}};

    always_comb begin
        case (sel)
            PCS_HELD: pc = held;
            PCS_JUMP: pc = jump_shifted;
            default:  pc = live;
        endcase
    end

endmodule

// File: rtl/alu_pc_unit.sv
module alu_pc_unit
    import alu_pc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FUNCT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DW-1:0]     opnd_a,
    input  logic [DW-1:0]     opnd_b,
    input  logic [MODE_W-1:0] alu_mode,
    input  logic [FW-1:0]     funct,
    input  logic [DW-1:0]     jump_field,
    input  logic [SEL_W-1:0]  pc_src,
    output logic [DW-1:0]     result,
    output logic              zero,
    output logic [DW-1:0]     next_pc
);

    alu_ctl_e      ctl;
    logic [DW-1:0] held_q;

    alu_op_decoder #(.FW(FW)) u_dec (
        .mode (alu_mode),
        .fn   (funct),
        .ctl  (ctl)
    );

    alu_core #(.W(DW)) u_core (
        .ctl  (ctl),
        .a    (opnd_a),
        .b    (opnd_b),
        .y    (result),
        .zero (zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else begin
            held_q <= result;
        end
    end

    pc_next_mux #(.W(DW), .SHIFT(2)) u_pcmux (
        .sel  (pc_src_e'(pc_src)),
        .live (result),
        .held (held_q),
        .jump (jump_field),
        .pc   (next_pc)
    );

    // R1: mode 00 must reach the core as add
    a_r1_mode_add : assert property (@(posedge clk) disable iff (rst)
        (alu_mode == 2'b00) |-> (ctl == CTL_ADD));

    // R2: mode 01 must reach the core as subtract
    a_r2_mode_sub : assert property (@(posedge clk) disable iff (rst)
        (alu_mode == 2'b01) |-> (ctl == CTL_SUB));

    // R5: set-less-than only ever drives bit zero
    a_r5_slt_binary : assert property (@(posedge clk) disable iff (rst)
        (ctl == CTL_SLT) |-> (result[DW-1:1] == '0));

    // R7: the held copy is always the previous cycle's result
    a_r7_hold_follows : assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (held_q == $past(result)));

    // R8: a jump target is always word aligned
    a_r8_jump_aligned : assert property (@(posedge clk) disable iff (rst)
        (pc_src == 2'b10) |-> (next_pc[1:0] == 2'b00));

endmodule

// File: tb/tb_alu_pc_unit.sv
module tb_alu_pc_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [1:0] alu_mode = '0;
    logic [5:0] funct = '0;
    logic [7:0] jump_field = '0;
    logic [1:0] pc_src = '0;
    logic [7:0] result;
    logic       zero;
    logic [7:0] next_pc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] prev_exp = '0;

    always #10 clk = ~clk;

    alu_pc_unit dut (
        .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .alu_mode(alu_mode), .funct(funct), .jump_field(jump_field),
        .pc_src(pc_src), .result(result), .zero(zero), .next_pc(next_pc)
    );

    function automatic logic [7:0] model(input logic [1:0] m, input logic [5:0] f,
                                         input logic [7:0] a, input logic [7:0] b);
        int op; // 0 add, 1 sub, 2 and, 3 or, 4 slt
        if (m == 2'b00) op = 0;
        else if (m == 2'b01) op = 1;
        else if (f == 6'd32) op = 0;
        else if (f == 6'd34) op = 1;
        else if (f == 6'd36) op = 2;
        else if (f == 6'd37) op = 3;
        else if (f == 6'd42) op = 4;
        else op = 0;
        case (op)
            0: return 8'((int'(a) + int'(b)) % 256);
            1: return 8'((int'(a) - int'(b) + 256) % 256);
            2: return a & b;
            3: return a | b;
            default: return ($signed(a) < $signed(b)) ? 8'd1 : 8'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (mode=%b funct=%b a=%h b=%h sel=%b)",
                     tag, act, exp, alu_mode, funct, opnd_a, opnd_b, pc_src);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic [5:0] f, input logic [7:0] a,
                        input logic [7:0] b, input logic [1:0] s, input logic [7:0] j,
                        input string tag);
        logic [7:0] e;
        logic [7:0] epc;
        @(negedge clk);
        alu_mode = m; funct = f; opnd_a = a; opnd_b = b; pc_src = s; jump_field = j;
        #2;
        e = model(m, f, a, b);
        chk(tag, result, e);
        chk("R6 zero flag", {7'd0, zero}, {7'd0, (e == 8'd0)});
        case (s)
            2'b01: epc = prev_exp;
            2'b10: epc = 8'((int'(j) * 4) % 256);
            default: epc = e;
        endcase
        chk((s == 2'b01) ? "R7 held result" : "R8 next_pc select", next_pc, epc);
        prev_exp = e;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [1:0] cm [9];
        logic [5:0] cf [9];
        string      ct [9];
        logic [7:0] corner [6];
        cm = '{2'b00, 2'b01, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b11};
        cf = '{6'd42, 6'd36, 6'd32, 6'd34, 6'd36, 6'd37, 6'd42, 6'd0, 6'd34};
        ct = '{"R1 mode add", "R2 mode sub", "R3 funct add", "R3 funct sub",
               "R3 funct and", "R3 funct or", "R5 slt", "R4 unknown funct",
               "R3 mode 11 sub"};
        corner = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFF};

        // R7: reset clears the held copy
        pc_src = 2'b01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset clears held", next_pc, 8'h00);
        rst = 1'b0;
        prev_exp = 8'h00;

        for (int c = 0; c < 9; c++) begin
            for (int a = 0; a < 256; a++) begin
                for (int bi = 0; bi < 16; bi++) begin
                    step(cm[c], cf[c], 8'(a), 8'(bi * 17), 2'((a + bi) % 4),
                         8'(a ^ (bi * 17)), ct[c]);
                end
            end
        end

        // R5: signed comparison across the sign boundary
        for (int i = 0; i < 6; i++) begin
            for (int k = 0; k < 6; k++) begin
                step(2'b10, 6'd42, corner[i], corner[k], 2'b00, 8'h00, "R5 slt corner");
            end
        end

        // R8: jump field with top bits set, and select 11
        step(2'b00, 6'd0, 8'h10, 8'h20, 2'b10, 8'hFF, "R8 jump drop");
        step(2'b00, 6'd0, 8'h10, 8'h20, 2'b11, 8'hC3, "R8 select 11");

        // R7: mid-run reset clears a nonzero held value
        step(2'b00, 6'd0, 8'h05, 8'h03, 2'b01, 8'h00, "R1 load held");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R7 mid-run reset", next_pc, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule